// File: doc/BRIEF.md
# Disk Task-File Register Set

This block is the device-side register file of a parallel-ATA style task file. A host reaches it over an 8-bit register bus with a 3-bit address, a read strobe, a write strobe and separate write and read data lines. The block holds a sector count register and three address byte registers (low, mid and high). Each of these four keeps its current byte and the byte it replaced, so the device can form either a 28-bit or a 48-bit block address from them. The block also holds a device/head register, a device control register, a status register and an interrupt request line.

On the core side the block continuously presents the assembled 48-bit address and the effective sector count. The view is 28-bit or 48-bit, as the `coreMode48` input selects. When a command ends, the device logic pulses a single completion strobe. The strobe carries the final address, the remaining sector count and the new status byte. The host acknowledges the resulting interrupt by reading status. Command decoding and the data path sit outside this block.

Register addresses: 0 sector count, 1 address low, 2 address mid, 3 address high, 4 device/head, 5 status (read only), 6 device control (write only). Reads of address 6 or 7 return zero.

Top module: `taskfile_regs`

## Requirements
- R1: A host write to address 0, 1, 2 or 3 moves that register's current byte into its previous slot and stores the written byte as the current byte.
- R2: With `coreMode48`=1, `coreLba` is {high.prev, mid.prev, low.prev, high.cur, mid.cur, low.cur}, with the most significant byte first.
- R3: With `coreMode48`=0, `coreLba` is 20 zero bits, then device/head bits 3:0, then high.cur, mid.cur and low.cur. The previous slots play no part in this view.
- R4: `coreCount` gives count.cur in 28-bit mode and {count.prev, count.cur} in 48-bit mode. A zero value reads as 256 in 28-bit mode and as 65536 in 48-bit mode.
- R5: Device control bit 7 is the high-order select. While it is 1, host reads of addresses 0 to 3 return the previous byte; while it is 0 they return the current byte. A write to address 6 loads the bit. A host write to any of addresses 0 to 4 clears it.
- R6: One cycle after `coreDone`, each address register holds the final address. The low register's current byte takes bits 7:0 and its previous byte bits 31:24. Mid takes bits 15:8 and 39:32, and high takes bits 23:16 and 47:40. The count register takes the final count, low byte as current. Status takes the final status byte. In 28-bit mode, device/head bits 3:0 take bits 27:24.
- R7: `coreDone` sets `irq` one cycle later when device control bit 1 (interrupt mask) is 0. When the mask is 1, `coreDone` leaves `irq` unchanged.
- R8: A host read of address 5 clears `irq` on that clock edge. If `coreDone` raises the interrupt in the same cycle, the interrupt stays set.
- R9: When status bit 7 (busy) is 1, a status read returns 0x80, with every other bit masked to zero. Otherwise it returns the stored byte. The bit order from 7 down to 0 is busy, ready, fault, seek-done, data-request, corrected, index, error.
- R10: After reset, status reads 0x50 and `irq` is 0. All byte registers and both control bits are zero, so the 28-bit count reads 256.
- R11: A host write to addresses 0 to 4 in the same cycle as `coreDone` is dropped. The completion values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostAddr | input | 3 | Host register address |
| hostRd | input | 1 | Host read strobe; a read of address 5 acknowledges the interrupt |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| coreMode48 | input | 1 | 1 selects the 48-bit view, 0 the 28-bit view |
| coreLba | output | 48 | Assembled block address |
| coreCount | output | 17 | Effective sector count, 1 to 65536 |
| coreDone | input | 1 | One-cycle command completion strobe |
| coreFinalLba | input | 48 | Final address written back at completion |
| coreFinalCount | input | 16 | Remaining sector count written back at completion |
| coreFinalStatus | input | 8 | Status byte written back at completion |

## Verification
The checker watches properties on every cycle. It confirms that a 48-bit host write to the low register shifts the old byte up into bits 31:24. It confirms that a completion is mirrored on `coreLba`. It confirms that `irq` rises only after an unmasked completion and falls after a status read. It also checks that the effective count is never zero and that a busy status read shows no other bits. The bench scenarios are needed for the things a property cannot show on its own. These are the high-order read selection and its clearing, the 28-bit assembly from the device/head nibble, the zero-count decoding in both modes, and the drop of a host write that collides with a completion.

// File: rtl/taskfile_pkg.sv
package taskfile_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int LBA_W = 48;
  localparam int CNT_W = 16;
  localparam int NUM_HIST = 4;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOW = 3'd1;
  localparam logic [ADDR_W-1:0] A_MID = 3'd2;
  localparam logic [ADDR_W-1:0] A_HIGH = 3'd3;
  localparam logic [ADDR_W-1:0] A_DEV = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd6;

  localparam int HOB_BIT = 7;
  localparam int MASK_BIT = 1;
  localparam int BUSY_BIT = 7;

  typedef struct packed {
    logic [NUM_HIST-1:0] wrHist;
    logic wrDev;
    logic wrCtrl;
    logic clrHob;
    logic coreLoad;
  } tfStrobes_t;
endpackage

// File: rtl/tf_histbyte.sv
module tf_histbyte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hostWr,
  input  logic [W-1:0] hostData,
  input  logic         coreLoad,
  input  logic [W-1:0] coreCur,
  input  logic [W-1:0] corePrev,
  output logic [W-1:0] curByte,
  output logic [W-1:0] prevByte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      curByte <= '0;
      prevByte <= '0;
    end else if (coreLoad) begin
      curByte <= coreCur;
      prevByte <= corePrev;
    end else if (hostWr) begin
      prevByte <= curByte;
      curByte <= hostData;
    end
  end
endmodule

// File: rtl/tf_control.sv
module tf_control
  import taskfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              coreDone,
  input  logic              intMask,
  output tfStrobes_t        strobes,
  output logic              irq
);
  logic ackRead;

  always_comb begin
    strobes = '0;
    strobes.coreLoad = coreDone;
    if (hostWr) begin
      for (int i = 0; i < NUM_HIST; i++) begin
        strobes.wrHist[i] = !coreDone && (hostAddr == ADDR_W'(i));
      end
      strobes.wrDev = !coreDone && (hostAddr == A_DEV);
      strobes.wrCtrl = (hostAddr == A_CTRL);
      strobes.clrHob = (hostAddr <= A_DEV);
    end
  end

  assign ackRead = hostRd && (hostAddr == A_STATUS);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (coreDone && !intMask) irq <= 1'b1;
    else if (ackRead) irq <= 1'b0;
  end
endmodule

// File: rtl/tf_datapath.sv
module tf_datapath
  import taskfile_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STATUS_RESET = 8'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  tfStrobes_t        strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic              coreMode48,
  output logic [LBA_W-1:0]  coreLba,
  output logic [CNT_W:0]    coreCount,
  input  logic [LBA_W-1:0]  coreFinalLba,
  input  logic [CNT_W-1:0]  coreFinalCount,
  input  logic [BYTE_W-1:0] coreFinalStatus,
  output logic              intMask
);
  localparam int CNT28_MAX = 1 << BYTE_W;
  localparam int CNT48_MAX = 1 << CNT_W;

  logic [BYTE_W-1:0] curB [NUM_HIST];
  logic [BYTE_W-1:0] prevB [NUM_HIST];
  logic [BYTE_W-1:0] loadCur [NUM_HIST];
  logic [BYTE_W-1:0] loadPrev [NUM_HIST];
  logic [BYTE_W-1:0] devHead, statusReg, ctrlReg, statusShown;
  logic [CNT_W-1:0] cnt16;

  // index 0 = count, 1 = low, 2 = mid, 3 = high (matches host address)
  assign loadCur[0] = coreFinalCount[7:0];
  assign loadPrev[0] = coreFinalCount[15:8];
  assign loadCur[1] = coreFinalLba[7:0];
  assign loadPrev[1] = coreFinalLba[31:24];
  assign loadCur[2] = coreFinalLba[15:8];
  assign loadPrev[2] = coreFinalLba[39:32];
  assign loadCur[3] = coreFinalLba[23:16];
  assign loadPrev[3] = coreFinalLba[47:40];

  for (genvar g = 0; g < NUM_HIST; g++) begin : g_hist
    tf_histbyte #(.W(BYTE_W)) u_hist (
      .clk(clk), .rst(rst),
      .hostWr(strobes.wrHist[g]), .hostData(hostWrData),
      .coreLoad(strobes.coreLoad), .coreCur(loadCur[g]), .corePrev(loadPrev[g]),
      .curByte(curB[g]), .prevByte(prevB[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      devHead <= '0;
      ctrlReg <= '0;
      statusReg <= STATUS_RESET;
    end else begin
      if (strobes.coreLoad) begin
        statusReg <= coreFinalStatus;
        if (!coreMode48) devHead[3:0] <= coreFinalLba[27:24];
      end else if (strobes.wrDev) begin
        devHead <= hostWrData;
      end
      if (strobes.wrCtrl) ctrlReg <= hostWrData;
      else if (strobes.clrHob) ctrlReg[HOB_BIT] <= 1'b0;
    end
  end

  assign intMask = ctrlReg[MASK_BIT];

  always_comb begin
    if (coreMode48) coreLba = {prevB[3], prevB[2], prevB[1], curB[3], curB[2], curB[1]};
    else coreLba = {20'd0, devHead[3:0], curB[3], curB[2], curB[1]};
  end

  assign cnt16 = {prevB[0], curB[0]};

  always_comb begin
    if (coreMode48) coreCount = (cnt16 == '0) ? (CNT_W+1)'(CNT48_MAX) : {1'b0, cnt16};
    else coreCount = (curB[0] == '0) ? (CNT_W+1)'(CNT28_MAX) : (CNT_W+1)'(curB[0]);
  end

  assign statusShown = statusReg[BUSY_BIT] ? 8'h80 : statusReg;

  always_comb begin
    hostRdData = '0;
    if (hostAddr <= A_HIGH) hostRdData = ctrlReg[HOB_BIT] ? prevB[hostAddr[1:0]] : curB[hostAddr[1:0]];
    else if (hostAddr == A_DEV) hostRdData = devHead;
    else if (hostAddr == A_STATUS) hostRdData = statusShown;
  end
endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
  import taskfile_pkg::*;
#(
  parameter logic [7:0] STATUS_RESET = 8'h50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  hostAddr,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  output logic        irq,
  input  logic        coreMode48,
  output logic [47:0] coreLba,
  output logic [16:0] coreCount,
  input  logic        coreDone,
  input  logic [47:0] coreFinalLba,
  input  logic [15:0] coreFinalCount,
  input  logic [7:0]  coreFinalStatus
);
  tfStrobes_t strobes;
  logic intMask;

  tf_control u_ctrl (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .coreDone(coreDone), .intMask(intMask), .strobes(strobes), .irq(irq)
  );

  tf_datapath #(.STATUS_RESET(STATUS_RESET)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .coreMode48(coreMode48),
    .coreLba(coreLba), .coreCount(coreCount), .coreFinalLba(coreFinalLba),
    .coreFinalCount(coreFinalCount), .coreFinalStatus(coreFinalStatus),
    .intMask(intMask)
  );
endmodule

// File: rtl/taskfile_checker.sv
module taskfile_checker (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  hostAddr,
  input logic        hostRd,
  input logic        hostWr,
  input logic [7:0]  hostWrData,
  input logic [7:0]  hostRdData,
  input logic        irq,
  input logic        coreMode48,
  input logic [47:0] coreLba,
  input logic [16:0] coreCount,
  input logic        coreDone,
  input logic [47:0] coreFinalLba,
  input logic        intMask
);
  // R1: 48-bit view shows the shifted low byte after a host write
  a_r1_low_shift: assert property (@(posedge clk) disable iff (rst)
    (coreMode48 && $past(coreMode48) && $past(hostWr && hostAddr == 3'd1 && !coreDone))
      |-> (coreLba[7:0] == $past(hostWrData) && coreLba[31:24] == $past(coreLba[7:0])));

  // R6: completion is mirrored on the 48-bit view
  a_r6_done_mirror: assert property (@(posedge clk) disable iff (rst)
    (coreMode48 && $past(coreMode48) && $past(coreDone)) |-> coreLba == $past(coreFinalLba));

  // R7: unmasked completion raises irq
  a_r7_irq_set: assert property (@(posedge clk) disable iff (rst)
    (coreDone && !intMask) |=> irq);

  // R7: irq only rises after a completion
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(coreDone));

  // R8: status read without a competing completion clears irq
  a_r8_ack_clear: assert property (@(posedge clk) disable iff (rst)
    (hostRd && hostAddr == 3'd5 && !coreDone) |=> !irq);

  // R4: effective count is never zero and never above 65536
  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    coreCount != 17'd0 && coreCount <= 17'd65536);

  // R9: busy status hides the other bits
  a_r9_busy_mask: assert property (@(posedge clk) disable iff (rst)
    (hostRd && hostAddr == 3'd5 && hostRdData[7]) |-> hostRdData[6:0] == 7'd0);
endmodule

bind taskfile_regs taskfile_checker u_chk (
  .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
  .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq),
  .coreMode48(coreMode48), .coreLba(coreLba), .coreCount(coreCount),
  .coreDone(coreDone), .coreFinalLba(coreFinalLba), .intMask(intMask)
);

// File: tb/taskfile_regs_tb.sv
module taskfile_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] hostAddr = '0;
  logic hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic irq;
  logic coreMode48 = 1'b0;
  logic [47:0] coreLba;
  logic [16:0] coreCount;
  logic coreDone = 1'b0;
  logic [47:0] coreFinalLba = '0;
  logic [15:0] coreFinalCount = '0;
  logic [7:0] coreFinalStatus = '0;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  taskfile_regs u_dut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic readCheck(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 check(tag, 64'(hostRdData), 64'(exp));
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic coreFinish(logic [47:0] l, logic [15:0] c, logic [7:0] s);
    @(negedge clk);
    coreFinalLba = l; coreFinalCount = c; coreFinalStatus = s; coreDone = 1'b1;
    @(negedge clk);
    coreDone = 1'b0;
  endtask

  task automatic testReset();
    check("R10 irq", 64'(irq), 0);
    check("R10 count256", 64'(coreCount), 256);
    check("R10 lba", 64'(coreLba), 0);
    readCheck(3'd5, 8'h50, "R10 status");
  endtask

  task automatic testHistory();
    coreMode48 = 1'b1;
    hostWrite(3'd1, 8'h11); hostWrite(3'd1, 8'h22);
    hostWrite(3'd2, 8'h33); hostWrite(3'd2, 8'h44);
    hostWrite(3'd3, 8'h55); hostWrite(3'd3, 8'h66);
    check("R1 R2 lba48", 64'(coreLba), 64'h5533_1166_4422);
    hostWrite(3'd6, 8'h80);
    readCheck(3'd1, 8'h11, "R5 hob low");
    readCheck(3'd2, 8'h33, "R5 hob mid");
    hostWrite(3'd1, 8'h77);
    readCheck(3'd1, 8'h77, "R5 hob cleared");
    check("R1 shift", 64'(coreLba[31:24]), 64'h22);
  endtask

  task automatic testMode28();
    coreMode48 = 1'b0;
    hostWrite(3'd4, 8'hE5);
    check("R3 lba28", 64'(coreLba), 64'h0000_0566_4477);
  endtask

  task automatic testCount();
    hostWrite(3'd0, 8'h00); hostWrite(3'd0, 8'h00);
    coreMode48 = 1'b1; #1 check("R4 zero48", 64'(coreCount), 65536);
    coreMode48 = 1'b0; #1 check("R4 zero28", 64'(coreCount), 256);
    hostWrite(3'd0, 8'h03); hostWrite(3'd0, 8'h00);
    coreMode48 = 1'b1; #1 check("R4 count48", 64'(coreCount), 768);
    coreMode48 = 1'b0; #1 check("R4 count28 zero", 64'(coreCount), 256);
  endtask

  task automatic testCompletion();
    coreMode48 = 1'b1;
    hostWrite(3'd6, 8'h00);
    coreFinish(48'hABCD_EF01_2345, 16'h0000, 8'h50);
    check("R6 lba", 64'(coreLba), 64'hABCD_EF01_2345);
    check("R7 irq set", 64'(irq), 1);
    readCheck(3'd0, 8'h00, "R6 count zero");
    readCheck(3'd5, 8'h50, "R6 status");
    check("R8 irq cleared", 64'(irq), 0);
    hostWrite(3'd6, 8'h02);
    coreFinish(48'h0, 16'h0102, 8'h51);
    check("R7 masked", 64'(irq), 0);
    readCheck(3'd0, 8'h02, "R6 count low");
    hostWrite(3'd6, 8'h82);
    readCheck(3'd0, 8'h01, "R6 count high");
    readCheck(3'd5, 8'h51, "R6 status2");
    coreMode48 = 1'b0;
    coreFinish(48'h0000_0A12_3456, 16'h0001, 8'h50);
    check("R6 dev nibble", 64'(coreLba), 64'h0000_0A12_3456);
  endtask

  task automatic testAckRace();
    hostWrite(3'd6, 8'h00);
    @(negedge clk);
    hostAddr = 3'd5; hostRd = 1'b1;
    coreFinalStatus = 8'h50; coreFinalLba = '0; coreFinalCount = '0; coreDone = 1'b1;
    @(negedge clk);
    hostRd = 1'b0; coreDone = 1'b0;
    check("R8 set wins", 64'(irq), 1);
    readCheck(3'd5, 8'h50, "R8 ack");
    check("R8 cleared", 64'(irq), 0);
  endtask

  task automatic testBusy();
    coreFinish(48'h0, 16'h0, 8'hD1);
    readCheck(3'd5, 8'h80, "R9 busy mask");
    coreFinish(48'h0, 16'h0, 8'h51);
    readCheck(3'd5, 8'h51, "R9 not busy");
  endtask

  task automatic testCollision();
    coreMode48 = 1'b1;
    @(negedge clk);
    hostAddr = 3'd1; hostWrData = 8'h99; hostWr = 1'b1;
    coreFinalLba = 48'h0000_0000_0045; coreFinalCount = 16'h0; coreFinalStatus = 8'h50; coreDone = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; coreDone = 1'b0;
    check("R11 core wins", 64'(coreLba), 64'h45);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testHistory();
    testMode28();
    testCount();
    testCompletion();
    testAckRace();
    testBusy();
    testCollision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule